// File: doc/BRIEF.md
# Conversion Trigger Mode Controller

This block decides when an on-chip ADC sequencer acquires and converts. A 2-bit mode input selects the start source. In software mode, conversions are started by a register-write strobe or by a continuous-conversion enable. In pin-edge mode, a falling edge on an active-low convert-start pin starts a conversion. In pin-timed mode, the low phase of that pin defines the acquisition window. One mode code is reserved and is locked out.

The block drives single-cycle acquire-start, acquire-end and convert-start pulses to a downstream converter model. It waits for a convert-done pulse from that model before it accepts another trigger. The pin passes through a two-stage synchronizer before any edge or level detection. In the modes where acquisition is timed internally, acquisition lasts a fixed number of clocks (`ACQ_CYCLES`, default 16).

Top module: `conv_trigger_ctrl`

## Requirements
- R1: In mode 2'b00, a `swStart` pulse seen at a clock edge raises `acqStart` for one cycle after that edge. After the pulse, `acqEnd` and `convStart` rise together exactly `ACQ_CYCLES` (16) cycles after `acqStart`.
- R2: While `busy` is high (from `acqStart` until the cycle after `convDone` is seen), triggers from `swStart` or the pin are ignored and are not stored. `busy` falls one cycle after `convDone`.
- R3: In mode 2'b00 with `contEn` high, acquisition starts without a strobe, and it restarts one cycle after `busy` falls following each `convDone`. Clearing `contEn` during a conversion stops the sequence after that conversion.
- R4: In mode 2'b01, a high-to-low transition of `cnvPinN` starts an internally timed acquisition of `ACQ_CYCLES` cycles. `swStart` and rising pin edges start nothing.
- R5: In mode 2'b11, a falling pin edge starts acquisition, and acquisition lasts as long as the pin is held low. The synchronized rising edge ends acquisition and raises `acqEnd` together with `convStart`.
- R6: Mode 2'b10 is reserved. While it is selected, no trigger starts acquisition. `modeErr` is high in the cycle after each edge at which the mode is 2'b10, and low otherwise.
- R7: `cnvPinN` passes through two synchronizing flip-flops. A pin transition driven between two clock edges produces its pulse after the third following edge.
- R8: `acqStart`, `acqEnd` and `convStart` are single-cycle pulses. After reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clkMode | input | 2 | Trigger mode: 00 software, 01 pin edge, 10 reserved, 11 pin timed |
| swStart | input | 1 | Start strobe from a write to the conversion register |
| contEn | input | 1 | Continuous-conversion enable (mode 00) |
| cnvPinN | input | 1 | Asynchronous active-low convert-start pin |
| convDone | input | 1 | Conversion-complete pulse from the converter |
| acqStart | output | 1 | Acquisition begins (pulse) |
| acqEnd | output | 1 | Acquisition ends (pulse) |
| convStart | output | 1 | Conversion begins (pulse) |
| busy | output | 1 | Acquisition or conversion in progress |
| modeErr | output | 1 | Reserved mode selected |

## Verification
Each fault in the control state shows at the ports within a few cycles:
- A start sequencer that leaves idle too early shows an extra `acqStart` pulse.
- One that never returns to idle shows `busy` stuck high after `convDone`.
- A wrong acquisition counter moves `acqEnd` away from the 16th cycle.
- A synchronizer depth error shifts the pin-to-pulse latency away from three edges.

The bench measures these latencies exactly and counts pulses over windows in which triggers must be ignored. The mode input is swept over all four codes to check the reserved-code flag.

// File: rtl/conv_trig_pkg.sv
package conv_trig_pkg;
  typedef enum logic [1:0] {
    MODE_SW        = 2'b00,
    MODE_PIN_EDGE  = 2'b01,
    MODE_RSVD      = 2'b10,
    MODE_PIN_TIMED = 2'b11
  } trig_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_ACQ  = 2'b01,
    ST_CONV = 2'b10
  } ctl_state_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic cntClr;
    logic cntRun;
  } dp_ctl_t;
endpackage

// File: rtl/trig_datapath.sv
module trig_datapath
  import conv_trig_pkg::*;
#(
  parameter int ACQ_CYCLES  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    cnvPinN,
  input  dp_ctl_t dpCtl,
  output logic    pinFall,
  output logic    pinRise,
  output logic    acqCntDone
);
  localparam int CNT_W = $clog2(ACQ_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ACQ_CYCLES - 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic pinPrev;
  logic [CNT_W-1:0] acqCnt;

  // Synchronizer chain, idle level high
  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[i] <= 1'b1;
        else if (i == 0) syncQ[i] <= cnvPinN;
        else syncQ[i] <= syncQ[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinPrev <= 1'b1;
    else       pinPrev <= syncQ[SYNC_STAGES-1];
  end

  assign pinFall = pinPrev & ~syncQ[SYNC_STAGES-1];
  assign pinRise = ~pinPrev & syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             acqCnt <= '0;
    else if (dpCtl.cntClr) acqCnt <= '0;
    else if (dpCtl.cntRun) acqCnt <= acqCnt + 1'b1;
  end

  assign acqCntDone = (acqCnt == CNT_LAST);
endmodule

// File: rtl/trig_control.sv
module trig_control
  import conv_trig_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] clkMode,
  input  logic       swStart,
  input  logic       contEn,
  input  logic       convDone,
  input  logic       pinFall,
  input  logic       pinRise,
  input  logic       acqCntDone,
  output dp_ctl_t    dpCtl,
  output logic       acqStart,
  output logic       acqEnd,
  output logic       convStart,
  output logic       busy,
  output logic       modeErr
);
  ctl_state_e state;
  logic pinTimed;
  logic trigHit;
  logic acqOver;

  always_comb begin
    unique case (clkMode)
      MODE_SW:        trigHit = swStart | contEn;
      MODE_PIN_EDGE:  trigHit = pinFall;
      MODE_PIN_TIMED: trigHit = pinFall;
      default:        trigHit = 1'b0;
    endcase
  end

  assign acqOver = pinTimed ? pinRise : acqCntDone;

  always_comb begin
    dpCtl.cntClr = (state != ST_ACQ);
    dpCtl.cntRun = (state == ST_ACQ) && !pinTimed;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      pinTimed  <= 1'b0;
      acqStart  <= 1'b0;
      acqEnd    <= 1'b0;
      convStart <= 1'b0;
      modeErr   <= 1'b0;
    end else begin
      acqStart  <= 1'b0;
      acqEnd    <= 1'b0;
      convStart <= 1'b0;
      modeErr   <= (clkMode == MODE_RSVD);
      unique case (state)
        ST_IDLE: if (trigHit) begin
          state    <= ST_ACQ;
          acqStart <= 1'b1;
          pinTimed <= (clkMode == MODE_PIN_TIMED);
        end
        ST_ACQ: if (acqOver) begin
          state     <= ST_CONV;
          acqEnd    <= 1'b1;
          convStart <= 1'b1;
        end
        ST_CONV: if (convDone) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/conv_trigger_ctrl.sv
module conv_trigger_ctrl
  import conv_trig_pkg::*;
#(
  parameter int ACQ_CYCLES  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] clkMode,
  input  logic       swStart,
  input  logic       contEn,
  input  logic       cnvPinN,
  input  logic       convDone,
  output logic       acqStart,
  output logic       acqEnd,
  output logic       convStart,
  output logic       busy,
  output logic       modeErr
);
  dp_ctl_t dpCtl;
  logic pinFall, pinRise, acqCntDone;

  trig_datapath #(.ACQ_CYCLES(ACQ_CYCLES), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .cnvPinN(cnvPinN), .dpCtl(dpCtl),
    .pinFall(pinFall), .pinRise(pinRise), .acqCntDone(acqCntDone)
  );

  trig_control u_ctl (
    .clk(clk), .rstN(rstN), .clkMode(clkMode), .swStart(swStart),
    .contEn(contEn), .convDone(convDone), .pinFall(pinFall),
    .pinRise(pinRise), .acqCntDone(acqCntDone), .dpCtl(dpCtl),
    .acqStart(acqStart), .acqEnd(acqEnd), .convStart(convStart),
    .busy(busy), .modeErr(modeErr)
  );
endmodule

// File: rtl/conv_trigger_ctrl_chk.sv
module conv_trigger_ctrl_chk (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] clkMode,
  input logic       acqStart,
  input logic       acqEnd,
  input logic       convStart,
  input logic       busy,
  input logic       modeErr
);
  a_r8_start_single: assert property (@(posedge clk) disable iff (!rstN)
    acqStart |=> !acqStart);
  a_r8_end_single: assert property (@(posedge clk) disable iff (!rstN)
    acqEnd |=> !acqEnd);
  a_r2_start_from_idle: assert property (@(posedge clk) disable iff (!rstN)
    acqStart |-> $past(!busy));
  a_r1_conv_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    convStart |-> busy);
  a_r6_no_start_reserved: assert property (@(posedge clk) disable iff (!rstN)
    (clkMode == 2'b10 && !busy) |=> !acqStart);
  a_r6_flag_raised: assert property (@(posedge clk) disable iff (!rstN)
    (clkMode == 2'b10) |=> modeErr);
  a_r6_flag_clear: assert property (@(posedge clk) disable iff (!rstN)
    (clkMode != 2'b10) |=> !modeErr);
endmodule

bind conv_trigger_ctrl conv_trigger_ctrl_chk u_chk (
  .clk(clk), .rstN(rstN), .clkMode(clkMode), .acqStart(acqStart),
  .acqEnd(acqEnd), .convStart(convStart), .busy(busy), .modeErr(modeErr)
);

// File: tb/tb_conv_trigger_ctrl.sv
module tb_conv_trigger_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int ACQ = 16;
  localparam int SYNC_LAT = 3;

  logic clk = 0, rstN = 0;
  logic [1:0] clkMode = 2'b00;
  logic swStart = 0, contEn = 0, cnvPinN = 1, convDone = 0;
  logic acqStart, acqEnd, convStart, busy, modeErr;
  int checks = 0, fails = 0;
  int startCnt = 0, endCnt = 0;

  conv_trigger_ctrl dut (
    .clk(clk), .rstN(rstN), .clkMode(clkMode), .swStart(swStart),
    .contEn(contEn), .cnvPinN(cnvPinN), .convDone(convDone),
    .acqStart(acqStart), .acqEnd(acqEnd), .convStart(convStart),
    .busy(busy), .modeErr(modeErr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (acqStart) startCnt++;
    if (acqEnd) endCnt++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  function automatic bit sigSel(input int sel);
    case (sel)
      0: return acqStart;
      1: return acqEnd;
      default: return !busy;
    endcase
  endfunction

  task automatic waitFor(input int sel, input int limit, output int n);
    n = 0;
    do begin
      tick();
      n++;
    end while (!sigSel(sel) && n < limit);
  endtask

  task automatic pulseDone();
    convDone = 1; tick(); convDone = 0;
  endtask

  initial begin
    int n, s0, e0;
    tick(3);
    chk({acqStart, acqEnd, convStart, busy, modeErr} == 5'b0, "R8 reset",
        {acqStart, acqEnd, convStart, busy, modeErr}, 0);
    rstN = 1; tick();

    // R6 sweep over every mode code
    for (int m = 0; m < 4; m++) begin
      clkMode = 2'(m); tick();
      chk(modeErr == (m == 2), "R6 flag sweep", modeErr, (m == 2));
    end
    clkMode = 2'b00; tick();

    // R1 software start, R2 ignore during acquisition and conversion
    s0 = startCnt;
    swStart = 1; tick(); swStart = 0;
    chk(acqStart == 1, "R1 start latency", acqStart, 1);
    tick(); chk(acqStart == 0, "R8 start single", acqStart, 0);
    swStart = 1; tick(); swStart = 0;
    waitFor(1, 40, n);
    chk(n == ACQ - 2, "R1 acq length", n + 2, ACQ);
    chk(convStart == 1, "R1 conv with end", convStart, 1);
    swStart = 1; tick(); swStart = 0; tick(3);
    chk(busy == 1, "R2 busy until done", busy, 1);
    pulseDone();
    chk(busy == 0, "R2 busy falls", busy, 0);
    tick(6);
    chk(startCnt - s0 == 1, "R2 triggers ignored", startCnt - s0, 1);

    // R3 continuous conversion
    s0 = startCnt;
    contEn = 1; tick();
    chk(acqStart == 1, "R3 cont start", acqStart, 1);
    waitFor(1, 40, n); pulseDone();
    chk(busy == 0, "R3 idle after done", busy, 0);
    tick();
    chk(acqStart == 1, "R3 auto restart", acqStart, 1);
    waitFor(1, 40, n);
    chk(n == ACQ, "R3 restart acq length", n, ACQ);
    contEn = 0; tick(2); pulseDone(); tick(8);
    chk(startCnt - s0 == 2, "R3 stop after clear", startCnt - s0, 2);

    // R4 pin-edge mode, R7 synchronizer latency
    clkMode = 2'b01; s0 = startCnt;
    swStart = 1; tick(); swStart = 0; tick(5);
    chk(startCnt == s0, "R4 strobe ignored", startCnt - s0, 0);
    cnvPinN = 0;
    waitFor(0, 10, n);
    chk(n == SYNC_LAT, "R7 fall latency", n, SYNC_LAT);
    waitFor(1, 40, n);
    chk(n == ACQ, "R4 acq length", n, ACQ);
    cnvPinN = 1; tick(4); cnvPinN = 0; tick(4);
    pulseDone(); cnvPinN = 1; tick(8);
    chk(startCnt - s0 == 1, "R4 edge in conv ignored, rise no start", startCnt - s0, 1);

    // R5 pin-timed mode
    clkMode = 2'b11; e0 = endCnt;
    cnvPinN = 0;
    waitFor(0, 10, n);
    chk(n == SYNC_LAT, "R5 start latency", n, SYNC_LAT);
    tick(40);
    chk(endCnt == e0 && busy, "R5 held while low", endCnt - e0, 0);
    cnvPinN = 1;
    waitFor(1, 10, n);
    chk(n == SYNC_LAT, "R7 rise latency", n, SYNC_LAT);
    chk(convStart == 1, "R5 conv on rise", convStart, 1);
    pulseDone(); tick(2);

    // R6 reserved mode lockout
    clkMode = 2'b10; s0 = startCnt;
    swStart = 1; contEn = 1; tick(); swStart = 0;
    cnvPinN = 0; tick(10);
    chk(startCnt == s0 && !busy, "R6 no start in reserved", startCnt - s0, 0);
    chk(modeErr == 1, "R6 flag held", modeErr, 1);
    contEn = 0; cnvPinN = 1; clkMode = 2'b00; tick(4);
    chk(modeErr == 0 && startCnt == s0, "R6 flag clear", modeErr, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule